// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode manager of a single-wire bus transceiver. It decides when the node may drive the bus, when the receive path is visible to the local controller, and when the external voltage regulator is powered through the inhibit output. The block has four modes: sleep, standby, normal and a dedicated bus-short mode. It moves between them based on a local enable pin, a local wake-up pin and the digitised bus level from the receive comparator.

Every asynchronous input is first resynchronised. Timing qualification is done with clock-count timers whose thresholds are parameters. An enable pulse, a dominant bus burst or a wake-pin change only counts once it has held a stable level for its full threshold. If the enable pin is dropped while the bus is stuck dominant, the node parks in the short mode. There the receive output floats and transmit data has no effect. The node drops to sleep by itself as soon as the bus goes recessive again.

Top module: `lin_mode_ctrl`

## Requirements
- R1: The mode output encodes sleep=00, standby=01, normal=10 and short=11. Reset places the block in standby (01).
- R2: In standby the receive output follows the synchronised bus level (1 = recessive) with its output enable high. The drive request stays 0 whatever the transmit input does.
- R3: Normal is entered from standby or from sleep only after the synchronised enable has been 1 for EN_CNT consecutive clocks. A shorter high pulse leaves the mode unchanged.
- R4: In normal the drive request equals the inverse of the synchronised transmit input (transmit 0 = dominant), and the receive output mirrors the bus.
- R5: In normal, when the enable has been 0 for SLEEP_CNT consecutive clocks and the bus is recessive, the block enters sleep. In sleep, inhibit is 0, the receive output enable is 0 with the receive output at 1, and the drive request is 0.
- R6: In normal, when the enable has been 0 for SLEEP_CNT consecutive clocks and the bus is dominant, the block enters short mode. There inhibit is 0, the receive output enable is 0, and the transmit input is ignored.
- R7: Short mode is left only when the synchronised bus becomes recessive, and the next mode is always sleep.
- R8: In sleep, a dominant bus level held for BUS_CNT consecutive clocks moves the block to standby, where the receive output shows 0. Shorter dominant bursts are discarded.
- R9: On entry to sleep the wake pin level is stored. A wake pin level that differs from the stored one for WAKE_CNT consecutive clocks, of either polarity, moves the block to standby. Shorter changes are discarded.
- R10: Each input passes through a two-flop synchronizer. A bus level change reaches the receive output after exactly two clock edges.
- R11: Inhibit is 1 exactly in standby and normal. It rises only when leaving sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Local enable request (asynchronous) |
| txd_i | input | 1 | Transmit data, 0 = dominant (asynchronous) |
| wake_i | input | 1 | Local wake-up pin, either edge (asynchronous) |
| bus_rx_i | input | 1 | Digitised bus comparator, 1 = recessive (asynchronous) |
| bus_dom_o | output | 1 | Request to the bus driver to pull dominant |
| rxd_o | output | 1 | Receive data to the controller |
| rxd_oe_o | output | 1 | Output enable of rxd_o, 0 = high impedance |
| inh_o | output | 1 | Inhibit switch for the external regulator |
| mode_o | output | 2 | Current mode code |

## Verification
A wrong mode register shows at once on mode_o, and within the same cycle on inh_o, rxd_oe_o and the drive request, because all of these are decoded from the mode. An off-by-one in a qualification timer moves a mode change by one clock. The bench therefore compares every output against a cycle-level model on every clock, and a single-cycle slip is reported at the first edge where it occurs. A wrongly stored wake level would either wake the block at once or never wake it; the sleep checks that follow a wake-pin change expose both faults.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
   typedef enum logic [1:0] {
      M_SLEEP = 2'b00,
      M_STBY  = 2'b01,
      M_NORM  = 2'b10,
      M_SHORT = 2'b11
   } lin_mode_e;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lin_hold_timer.sv
module lin_hold_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic cond_i,
   output logic qual_o
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("lin_hold_timer: LIMIT must be at least 1");
   end

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr_i || !cond_i) cnt <= '0;
      else if (cnt != LIM)       cnt <= cnt + 1'b1;
   end

   assign qual_o = (cnt == LIM);

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM);
   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cond_i || clr_i) |=> (cnt == '0));
endmodule

// File: rtl/lin_local_wake.sv
module lin_local_wake #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic capture_i,
   input  logic lvl_i,
   output logic hit_o
);
   logic stored;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stored <= 1'b0;
      else if (capture_i) stored <= lvl_i;
   end

   lin_hold_timer #(.LIMIT(LIMIT)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!arm_i),
      .cond_i (lvl_i != stored),
      .qual_o (hit_o)
   );

   assert_disarmed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_i) |=> !hit_o);
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int EN_CNT    = 3200,
   parameter int SLEEP_CNT = 3200,
   parameter int BUS_CNT   = 3200,
   parameter int WAKE_CNT  = 3200,
   parameter int SYNC_STG  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       txd_i,
   input  logic       wake_i,
   input  logic       bus_rx_i,
   output logic       bus_dom_o,
   output logic       rxd_o,
   output logic       rxd_oe_o,
   output logic       inh_o,
   output logic [1:0] mode_o
);
   localparam int NIN = 4;
   localparam logic [NIN-1:0] IN_RST = 4'b0101;

   logic [NIN-1:0] s_vec;
   logic s_en, s_txd, s_wake, s_bus;
   logic en_hi_q, en_lo_q, bus_dom_q, wake_q;
   lin_mode_e mode, mode_nx;

   lin_sync #(.W(NIN), .STAGES(SYNC_STG), .RST_VAL(IN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({en_i, txd_i, wake_i, bus_rx_i}),
      .q_o   (s_vec)
   );
   assign {s_en, s_txd, s_wake, s_bus} = s_vec;

   lin_hold_timer #(.LIMIT(EN_CNT)) u_en_hi (
      .clk(clk), .rst_n(rst_n), .clr_i(mode == M_NORM),
      .cond_i(s_en), .qual_o(en_hi_q));

   lin_hold_timer #(.LIMIT(SLEEP_CNT)) u_en_lo (
      .clk(clk), .rst_n(rst_n), .clr_i(mode != M_NORM),
      .cond_i(!s_en), .qual_o(en_lo_q));

   lin_hold_timer #(.LIMIT(BUS_CNT)) u_bus_wk (
      .clk(clk), .rst_n(rst_n), .clr_i(mode != M_SLEEP),
      .cond_i(!s_bus), .qual_o(bus_dom_q));

   lin_local_wake #(.LIMIT(WAKE_CNT)) u_loc_wk (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (mode == M_SLEEP),
      .capture_i ((mode_nx == M_SLEEP) && (mode != M_SLEEP)),
      .lvl_i     (s_wake),
      .hit_o     (wake_q)
   );

   always_comb begin
      mode_nx = mode;
      unique case (mode)
         M_STBY:  if (en_hi_q) mode_nx = M_NORM;
         M_NORM:  if (en_lo_q) mode_nx = s_bus ? M_SLEEP : M_SHORT;
         M_SLEEP: begin
            if (en_hi_q)                  mode_nx = M_NORM;
            else if (bus_dom_q || wake_q) mode_nx = M_STBY;
         end
         M_SHORT: if (s_bus) mode_nx = M_SLEEP;
         default: mode_nx = M_STBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= M_STBY;
      else        mode <= mode_nx;
   end

   logic awake;
   assign awake     = (mode == M_STBY) || (mode == M_NORM);
   assign bus_dom_o = (mode == M_NORM) && !s_txd;
   assign rxd_oe_o  = awake;
   assign rxd_o     = awake ? s_bus : 1'b1;
   assign inh_o     = awake;
   assign mode_o    = mode;

   assert_short_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11) |=> (mode_o == 2'b11 || mode_o == 2'b00));
   assert_short_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11 && $past(mode_o) != 2'b11) |-> $past(!s_bus));
   assert_norm_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10 && $past(mode_o) != 2'b10) |-> $past(en_hi_q));
   assert_tx_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'b10) |-> !bus_dom_o);
   assert_inh_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inh_o) |-> ($past(mode_o) == 2'b00));
   assert_float_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rxd_oe_o |-> rxd_o);
endmodule

// File: tb/sim_lin_mode_ctrl.sv
module sim_lin_mode_ctrl;
   localparam int P_EN = 5, P_SLP = 6, P_BUS = 7, P_WK = 4;

   logic clk = 0, rst_n = 0;
   logic en_i = 0, txd_i = 1, wake_i = 0, bus_rx_i = 1;
   logic bus_dom_o, rxd_o, rxd_oe_o, inh_o;
   logic [1:0] mode_o;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   lin_mode_ctrl #(.EN_CNT(P_EN), .SLEEP_CNT(P_SLP), .BUS_CNT(P_BUS),
                   .WAKE_CNT(P_WK)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .txd_i(txd_i), .wake_i(wake_i),
      .bus_rx_i(bus_rx_i), .bus_dom_o(bus_dom_o), .rxd_o(rxd_o),
      .rxd_oe_o(rxd_oe_o), .inh_o(inh_o), .mode_o(mode_o));

   // behavioural reference model
   bit m1_en, m1_tx, m1_wk, m1_bus, m2_en, m2_tx, m2_wk, m2_bus, m_stored;
   int c_hi, c_lo, c_bd, c_wk;
   int m_mode;  // 0 sleep, 1 standby, 2 normal, 3 short

   always @(posedge clk) begin
      if (!rst_n) begin
         {m1_en, m1_tx, m1_wk, m1_bus} = 4'b0101;
         {m2_en, m2_tx, m2_wk, m2_bus} = 4'b0101;
         m_stored = 0; c_hi = 0; c_lo = 0; c_bd = 0; c_wk = 0; m_mode = 1;
      end else begin
         int nm;
         nm = m_mode;
         case (m_mode)
            1: if (c_hi == P_EN) nm = 2;
            2: if (c_lo == P_SLP) nm = m2_bus ? 0 : 3;
            0: if (c_hi == P_EN) nm = 2;
               else if (c_bd == P_BUS || c_wk == P_WK) nm = 1;
            default: if (m2_bus) nm = 0;
         endcase
         c_hi = (m_mode != 2 && m2_en)        ? ((c_hi < P_EN)  ? c_hi + 1 : c_hi) : 0;
         c_lo = (m_mode == 2 && !m2_en)       ? ((c_lo < P_SLP) ? c_lo + 1 : c_lo) : 0;
         c_bd = (m_mode == 0 && !m2_bus)      ? ((c_bd < P_BUS) ? c_bd + 1 : c_bd) : 0;
         c_wk = (m_mode == 0 && m2_wk != m_stored) ? ((c_wk < P_WK) ? c_wk + 1 : c_wk) : 0;
         if (nm == 0 && m_mode != 0) m_stored = m2_wk;
         {m2_en, m2_tx, m2_wk, m2_bus} = {m1_en, m1_tx, m1_wk, m1_bus};
         {m1_en, m1_tx, m1_wk, m1_bus} = {en_i, txd_i, wake_i, bus_rx_i};
         m_mode = nm;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) if (rst_n) begin
      bit aw;
      aw = (m_mode == 1 || m_mode == 2);
      chk(mode_o == 2'(m_mode), "R1 mode", mode_o, m_mode);
      chk(bus_dom_o == (m_mode == 2 && !m2_tx), "R4 drive", bus_dom_o, int'(m_mode == 2 && !m2_tx));
      chk(rxd_o == (aw ? m2_bus : 1'b1), "R2 rxd", rxd_o, int'(aw ? m2_bus : 1'b1));
      chk(rxd_oe_o == aw, "R5 rxd_oe", rxd_oe_o, int'(aw));
      chk(inh_o == aw, "R11 inh", inh_o, int'(aw));
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      cyc(200000);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
      $finish;
   end

   initial begin
      cyc(4);
      rst_n = 1;
      cyc(1);
      chk(mode_o == 2'b01, "R1 reset", mode_o, 1);
      // R2 standby ignores transmit, receive follows bus
      txd_i = 0; cyc(10);
      chk(bus_dom_o == 0, "R2 tx ignored", bus_dom_o, 0);
      txd_i = 1;
      // R10 two-edge latency
      bus_rx_i = 0; cyc(1);
      chk(rxd_o == 1, "R10 one edge", rxd_o, 1);
      cyc(1);
      chk(rxd_o == 0, "R10 two edges", rxd_o, 0);
      cyc(5); bus_rx_i = 1; cyc(5);
      // R3 short enable pulse is discarded
      en_i = 1; cyc(3); en_i = 0; cyc(20);
      chk(mode_o == 2'b01, "R3 glitch", mode_o, 1);
      en_i = 1; cyc(20);
      chk(mode_o == 2'b10, "R3 normal", mode_o, 2);
      txd_i = 0; cyc(3);
      chk(bus_dom_o == 1, "R4 dominant", bus_dom_o, 1);
      txd_i = 1; cyc(3);
      chk(bus_dom_o == 0, "R4 recessive", bus_dom_o, 0);
      // R5 sleep
      en_i = 0; cyc(20);
      chk(mode_o == 2'b00, "R5 sleep", mode_o, 0);
      chk(inh_o == 0 && rxd_oe_o == 0, "R5 outputs", {inh_o, rxd_oe_o}, 0);
      // R8 remote wake
      bus_rx_i = 0; cyc(4); bus_rx_i = 1; cyc(20);
      chk(mode_o == 2'b00, "R8 burst discarded", mode_o, 0);
      bus_rx_i = 0; cyc(15);
      chk(mode_o == 2'b01 && rxd_o == 0, "R8 wake", {mode_o, rxd_o}, 2);
      chk(inh_o == 1, "R11 inh after wake", inh_o, 1);
      bus_rx_i = 1; cyc(5);
      // R6 short mode
      en_i = 1; cyc(20);
      bus_rx_i = 0; cyc(5);
      en_i = 0; cyc(20);
      chk(mode_o == 2'b11, "R6 short", mode_o, 3);
      chk(rxd_oe_o == 0 && inh_o == 0, "R6 outputs", {rxd_oe_o, inh_o}, 0);
      txd_i = 0; cyc(4);
      chk(bus_dom_o == 0, "R6 tx ignored", bus_dom_o, 0);
      txd_i = 1; cyc(40);
      chk(mode_o == 2'b11, "R7 held", mode_o, 3);
      bus_rx_i = 1; cyc(5);
      chk(mode_o == 2'b00, "R7 to sleep", mode_o, 0);
      // R9 local wake, rising
      wake_i = 1; cyc(2); wake_i = 0; cyc(20);
      chk(mode_o == 2'b00, "R9 glitch", mode_o, 0);
      wake_i = 1; cyc(15);
      chk(mode_o == 2'b01, "R9 rising", mode_o, 1);
      // R9 local wake, falling
      en_i = 1; cyc(20); en_i = 0; cyc(20);
      chk(mode_o == 2'b00, "R9 asleep", mode_o, 0);
      cyc(10);
      chk(mode_o == 2'b00, "R9 stored level", mode_o, 0);
      wake_i = 0; cyc(15);
      chk(mode_o == 2'b01, "R9 falling", mode_o, 1);
      // R3 sleep straight to normal
      en_i = 1; cyc(20); en_i = 0; cyc(20);
      en_i = 1; cyc(20);
      chk(mode_o == 2'b10, "R3 from sleep", mode_o, 2);
      cyc(5);
      summary();
      $finish;
   end
endmodule